// File: doc/BRIEF.md
# Battery learning-cycle status flags

This block holds the status bits that a battery fuel gauge uses to decide whether its learned full-charge capacity can be trusted and whether a new learning step may take place. It watches a per-sample strobe from the measurement front end. On each sample it tests three things: a taper-current condition, the pack voltage against two end-of-discharge thresholds, and the remaining capacity against a fixed fraction of the full capacity. From these it keeps a taper flag, a first-threshold and a final-threshold discharge flag, a valid-discharge flag, a calibration-busy flag and a capacity-inaccurate flag.

The capacity-inaccurate flag tells software that the learned capacity is stale. It is set by a full reset, by a partial reset that finds RAM corrupted, and by a build-up of charge-cycle increments since the last learning step. Only a completed learning step clears it. A learning step is requested by a single-cycle pulse. The pulse is raised when the first discharge flag goes from 0 to 1 while a qualified discharge is in progress. Threshold storage, the measurement path and the host bus lie outside the block.

Top module: `battery_learn_flags`

## Requirements
- R1: `taperFlag` becomes 1 on the sample at which `taperOk` has been 1 for TAPER_N (4) samples in a row. A sample with `taperOk` at 0 clears the run count and the flag.
- R2: `capInaccurate` is 1 after `rst_n` is released. It is set by a cycle with `fullRst` high, and by a cycle with `partRst` and `ramBad` both high.
- R3: `capInaccurate` sets on the STALE_N-th (32nd) `cycleInc` cycle counted since the last learning update. The counter saturates there.
- R4: The cycle after an `updateReq` pulse, `capInaccurate` is 0 and the increment count restarts from zero. A partial reset with `ramBad` low keeps both `capInaccurate` and the increment count.
- R5: `calBusy` equals the `calActive` value of the previous cycle, and is 0 after a reset cycle.
- R6: `validDis` sets the cycle after `qualify`. It clears after `disqualify`, after `updateReq` and after any reset. `disqualify` wins over `qualify`.
- R7: On a sample, `edvFirst` is loaded with (`vBat` <= `edv1Th`) and (16·`remCap` <= `fullCap`). It holds between samples.
- R8: On a sample, `edvFinal` is loaded with (`vBat` <= `edvfTh`). It holds between samples.
- R9: `updateReq` is high for exactly the one cycle after a sample at which `edvFirst` goes 0→1 while `validDis` is 1. It stays low in every other case.
- R10: A cycle with `fullRst` or `partRst` high clears `taperFlag`, `calBusy`, `validDis`, `edvFirst`, `edvFinal` and `updateReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low, acts as a full reset |
| fullRst | input | 1 | Synchronous full reset |
| partRst | input | 1 | Synchronous partial reset |
| ramBad | input | 1 | RAM corruption found, qualifies `partRst` |
| sampleStb | input | 1 | One-cycle strobe per averaged measurement |
| taperOk | input | 1 | Taper-current condition for this sample |
| vBat | input | VW | Pack voltage |
| edv1Th | input | VW | First end-of-discharge threshold |
| edvfTh | input | VW | Final end-of-discharge threshold |
| remCap | input | CW | Remaining capacity |
| fullCap | input | CW | Learned full capacity |
| cycleInc | input | 1 | Charge-cycle increment, one per high cycle |
| calActive | input | 1 | Offset calibration running |
| qualify | input | 1 | Discharge qualifies for learning |
| disqualify | input | 1 | Discharge no longer qualifies |
| taperFlag | output | 1 | Taper detected |
| capInaccurate | output | 1 | Learned capacity is stale |
| calBusy | output | 1 | Calibration in progress |
| validDis | output | 1 | Valid learning discharge |
| edvFirst | output | 1 | First end-of-discharge reached |
| edvFinal | output | 1 | Final end-of-discharge reached |
| updateReq | output | 1 | One-cycle request to learn the full capacity |

## Verification
The bench sweeps every 8-sample pattern of taper conditions against a run-length model. A design that counts non-consecutive samples, or that fails to clear on a bad sample, shows a flag on the wrong sample. Voltage and capacity are swept across both thresholds, with full-capacity values on either side of the one-sixteenth boundary. An off-by-one comparison or a wrong scale then shows at the edge. The increment counter is driven to 31 and 32 across a clean partial reset, a corrupting partial reset and a learning update. A counter that is wrongly cleared or kept then sets the stale flag too early or too late. Learning requests are tried with the first flag already high, with the discharge disqualified and with a valid edge. A level-triggered or ungated request fires where none is due.

// File: rtl/learn_pkg.sv
package learn_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrTaper;  // restart taper run count
    logic clrStale;  // restart increment count
    logic incEn;     // increments may be counted this cycle
    logic sample;    // qualified sample strobe
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic taperFull;
    logic staleHit;
    logic edv1Now;
    logic edvfNow;
  } dpStat_t;
endpackage

// File: rtl/learn_datapath.sv
module learn_datapath
  import learn_pkg::*;
#(
  parameter int VW = 12,
  parameter int CW = 16,
  parameter int TAPER_N = 4,
  parameter int STALE_N = 32,
  parameter int SOC_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dpCtl_t        ctl,
  input  logic          taperOk,
  input  logic          cycleInc,
  input  logic [VW-1:0] vBat,
  input  logic [VW-1:0] edv1Th,
  input  logic [VW-1:0] edvfTh,
  input  logic [CW-1:0] remCap,
  input  logic [CW-1:0] fullCap,
  output dpStat_t       stat
);
  localparam int TW = $clog2(TAPER_N + 1);
  localparam int SW = $clog2(STALE_N + 1);
  localparam int XW = CW + SOC_SHIFT;

  logic [TW-1:0] taperCnt;
  logic [SW-1:0] staleCnt;
  logic [XW-1:0] scaledRem;
  logic [XW-1:0] fullExt;
  logic          incNow;

  assign incNow = cycleInc && ctl.incEn;

  // run length of consecutive good taper samples, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taperCnt <= '0;
    else if (ctl.clrTaper) taperCnt <= '0;
    else if (ctl.sample) begin
      if (!taperOk) taperCnt <= '0;
      else if (taperCnt != TW'(TAPER_N)) taperCnt <= taperCnt + TW'(1);
    end
  end

  // increments since last learning step, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) staleCnt <= '0;
    else if (ctl.clrStale) staleCnt <= '0;
    else if (incNow && staleCnt != SW'(STALE_N)) staleCnt <= staleCnt + SW'(1);
  end

  assign scaledRem = {remCap, {SOC_SHIFT{1'b0}}};
  assign fullExt   = {{SOC_SHIFT{1'b0}}, fullCap};

  always_comb begin
    stat.taperFull = (taperCnt == TW'(TAPER_N));
    stat.staleHit  = incNow && !ctl.clrStale && (staleCnt == SW'(STALE_N - 1));
    stat.edv1Now   = (vBat <= edv1Th) && (scaledRem <= fullExt);
    stat.edvfNow   = (vBat <= edvfTh);
  end
endmodule

// File: rtl/learn_control.sv
module learn_control
  import learn_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fullRst,
  input  logic    partRst,
  input  logic    ramBad,
  input  logic    sampleStb,
  input  logic    calActive,
  input  logic    qualify,
  input  logic    disqualify,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    capInaccurate,
  output logic    calBusy,
  output logic    validDis,
  output logic    edvFirst,
  output logic    edvFinal,
  output logic    updateReq
);
  logic anyRst;
  logic hardRst;

  assign anyRst  = fullRst || partRst;
  assign hardRst = fullRst || (partRst && ramBad);

  always_comb begin
    ctl.clrTaper = anyRst;
    ctl.clrStale = hardRst || updateReq;
    ctl.incEn    = !anyRst;
    ctl.sample   = sampleStb && !anyRst;
  end

  // stale-capacity flag: only a learning step clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capInaccurate <= 1'b1;
    else if (hardRst) capInaccurate <= 1'b1;
    else if (partRst) capInaccurate <= capInaccurate;
    else if (updateReq) capInaccurate <= 1'b0;
    else if (stat.staleHit) capInaccurate <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calBusy   <= 1'b0;
      validDis  <= 1'b0;
      edvFirst  <= 1'b0;
      edvFinal  <= 1'b0;
      updateReq <= 1'b0;
    end else if (anyRst) begin
      calBusy   <= 1'b0;
      validDis  <= 1'b0;
      edvFirst  <= 1'b0;
      edvFinal  <= 1'b0;
      updateReq <= 1'b0;
    end else begin
      calBusy <= calActive;
      if (updateReq || disqualify) validDis <= 1'b0;
      else if (qualify) validDis <= 1'b1;
      if (sampleStb) begin
        edvFirst <= stat.edv1Now;
        edvFinal <= stat.edvfNow;
      end
      // rising edge against the flag held from the previous sample
      updateReq <= sampleStb && stat.edv1Now && !edvFirst && validDis;
    end
  end
endmodule

// File: rtl/battery_learn_flags.sv
module battery_learn_flags
  import learn_pkg::*;
#(
  parameter int VW = 12,
  parameter int CW = 16,
  parameter int TAPER_N = 4,
  parameter int STALE_N = 32,
  parameter int SOC_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fullRst,
  input  logic          partRst,
  input  logic          ramBad,
  input  logic          sampleStb,
  input  logic          taperOk,
  input  logic [VW-1:0] vBat,
  input  logic [VW-1:0] edv1Th,
  input  logic [VW-1:0] edvfTh,
  input  logic [CW-1:0] remCap,
  input  logic [CW-1:0] fullCap,
  input  logic          cycleInc,
  input  logic          calActive,
  input  logic          qualify,
  input  logic          disqualify,
  output logic          taperFlag,
  output logic          capInaccurate,
  output logic          calBusy,
  output logic          validDis,
  output logic          edvFirst,
  output logic          edvFinal,
  output logic          updateReq
);
  dpCtl_t  ctl;
  dpStat_t stat;

  learn_datapath #(
    .VW(VW), .CW(CW), .TAPER_N(TAPER_N), .STALE_N(STALE_N), .SOC_SHIFT(SOC_SHIFT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .taperOk(taperOk), .cycleInc(cycleInc),
    .vBat(vBat), .edv1Th(edv1Th), .edvfTh(edvfTh), .remCap(remCap),
    .fullCap(fullCap), .stat(stat)
  );

  learn_control u_ctl (
    .clk(clk), .rst_n(rst_n), .fullRst(fullRst), .partRst(partRst), .ramBad(ramBad),
    .sampleStb(sampleStb), .calActive(calActive), .qualify(qualify),
    .disqualify(disqualify), .stat(stat), .ctl(ctl), .capInaccurate(capInaccurate),
    .calBusy(calBusy), .validDis(validDis), .edvFirst(edvFirst), .edvFinal(edvFinal),
    .updateReq(updateReq)
  );

  assign taperFlag = stat.taperFull;
endmodule

// File: rtl/learn_flags_chk.sv
module learn_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic fullRst,
  input logic partRst,
  input logic ramBad,
  input logic sampleStb,
  input logic taperOk,
  input logic calActive,
  input logic qualify,
  input logic updateReq,
  input logic taperFlag,
  input logic capInaccurate,
  input logic calBusy,
  input logic validDis,
  input logic edvFirst,
  input logic edvFinal
);
  assert_upd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    updateReq |=> !updateReq);

  assert_upd_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    updateReq |-> $past(validDis) && $past(sampleStb));

  assert_upd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (updateReq && !fullRst && !partRst) |=> !capInaccurate && !validDis);

  assert_cal_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fullRst && !partRst) |=> calBusy == $past(calActive));

  assert_full_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fullRst |=> capInaccurate && !taperFlag && !validDis && !edvFirst && !edvFinal);

  assert_part_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (partRst && !ramBad && !fullRst) |=> $stable(capInaccurate));

  assert_taper_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(taperFlag) |-> $past(sampleStb) && $past(taperOk));

  assert_edvf_sampled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sampleStb) && !$past(fullRst) && !$past(partRst)) |-> $stable(edvFinal));

  assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(validDis) |-> $past(qualify));
endmodule

bind battery_learn_flags learn_flags_chk u_chk (.*);

// File: tb/tb_battery_learn_flags.sv
module tb_battery_learn_flags;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 12;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n, fullRst, partRst, ramBad, sampleStb, taperOk;
  logic [VW-1:0] vBat, edv1Th, edvfTh;
  logic [CW-1:0] remCap, fullCap;
  logic cycleInc, calActive, qualify, disqualify;
  logic taperFlag, capInaccurate, calBusy, validDis, edvFirst, edvFinal, updateReq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  battery_learn_flags dut (.*);

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic doSample();
    @(negedge clk) sampleStb = 1'b1;
    @(negedge clk) sampleStb = 1'b0;
  endtask

  task automatic pulseQual();
    @(negedge clk) qualify = 1'b1;
    @(negedge clk) qualify = 1'b0;
  endtask

  task automatic incCycles(input int n);
    @(negedge clk) cycleInc = 1'b1;
    repeat (n) @(negedge clk);
    cycleInc = 1'b0;
  endtask

  task automatic pulsePart(input logic bad);
    @(negedge clk) begin partRst = 1'b1; ramBad = bad; end
    @(negedge clk) begin partRst = 1'b0; ramBad = 1'b0; end
  endtask

  // drive a learning step: qualify, clear first flag, then raise it
  task automatic learnStep();
    pulseQual();
    vBat = 12'd2000; remCap = 16'd1000;
    doSample();
    vBat = 12'd1000; remCap = 16'd100;
    doSample();
    check(updateReq, 1, "R9 learn request");
    @(negedge clk);
    check(updateReq, 0, "R9 request one cycle");
    check(capInaccurate, 0, "R4 cleared by update");
    check(validDis, 0, "R6 cleared by update");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fullRst = 0; partRst = 0; ramBad = 0; sampleStb = 0; taperOk = 0;
    vBat = 12'd2000; edv1Th = 12'd1000; edvfTh = 12'd900;
    remCap = 16'd1000; fullCap = 16'd1600;
    cycleInc = 0; calActive = 0; qualify = 0; disqualify = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(capInaccurate, 1, "R2 power-on");
    check({taperFlag, calBusy, validDis, edvFirst, edvFinal, updateReq}, 0, "R10 power-on clear");

    // R5
    @(negedge clk) calActive = 1'b1;
    @(negedge clk) check(calBusy, 1, "R5 follow high");
    calActive = 1'b0;
    @(negedge clk) check(calBusy, 0, "R5 follow low");

    // R1 sweep over all 8-sample taper patterns
    begin
      int run = 0;
      for (int pat = 0; pat < 256; pat++) begin
        for (int b = 0; b < 8; b++) begin
          taperOk = pat[b];
          run = taperOk ? ((run < 4) ? run + 1 : 4) : 0;
          doSample();
          check(taperFlag, (run == 4) ? 1 : 0, "R1 taper run");
        end
      end
      taperOk = 1'b0;
      doSample();
    end

    // R7 sweep, no valid discharge so no request
    for (int fi = 0; fi < 3; fi++) begin
      fullCap = (fi == 0) ? 16'd1600 : (fi == 1) ? 16'd1615 : 16'd1616;
      for (int dv = -1; dv <= 1; dv++) begin
        vBat = VW'(1000 + dv);
        for (int r = 95; r <= 105; r++) begin
          remCap = CW'(r);
          doSample();
          check(edvFirst, ((1000 + dv) <= 1000 && r * 16 <= int'(fullCap)) ? 1 : 0, "R7 first threshold");
          check(updateReq, 0, "R9 no request without valid discharge");
        end
      end
    end
    fullCap = 16'd1600;

    // R8 sweep
    for (int v = 895; v <= 905; v++) begin
      vBat = VW'(v);
      doSample();
      check(edvFinal, (v <= 900) ? 1 : 0, "R8 final threshold");
      @(negedge clk);
      check(edvFinal, (v <= 900) ? 1 : 0, "R8 holds between samples");
    end

    // R6 and R9: qualify while first flag already high, no edge
    vBat = 12'd1000; remCap = 16'd100;
    doSample();
    pulseQual();
    check(validDis, 1, "R6 set by qualify");
    doSample();
    check(updateReq, 0, "R9 no edge no request");
    // disqualify wins and blocks request
    @(negedge clk) disqualify = 1'b1;
    @(negedge clk) disqualify = 1'b0;
    check(validDis, 0, "R6 cleared by disqualify");
    vBat = 12'd2000; doSample();
    vBat = 12'd1000; doSample();
    check(updateReq, 0, "R9 disqualified no request");
    @(negedge clk) begin qualify = 1'b1; disqualify = 1'b1; end
    @(negedge clk) begin qualify = 1'b0; disqualify = 1'b0; end
    check(validDis, 0, "R6 disqualify priority");

    // first learning step clears power-on stale flag
    learnStep();

    // R3
    incCycles(31);
    check(capInaccurate, 0, "R3 31 increments");
    incCycles(1);
    check(capInaccurate, 1, "R3 32nd increment");
    incCycles(5);
    check(capInaccurate, 1, "R3 saturated");
    learnStep();

    // R4 clean partial reset keeps count
    incCycles(20);
    pulsePart(1'b0);
    check(capInaccurate, 0, "R4 partial keeps flag");
    incCycles(11);
    check(capInaccurate, 0, "R4 count kept 31");
    incCycles(1);
    check(capInaccurate, 1, "R4 count kept 32");
    learnStep();

    // R2 corrupt partial reset
    incCycles(20);
    pulsePart(1'b1);
    check(capInaccurate, 1, "R2 partial with corruption");
    learnStep();
    incCycles(31);
    check(capInaccurate, 0, "R4 count restarted by update");
    learnStep();

    // R10 set many flags then full reset
    calActive = 1'b1; taperOk = 1'b1;
    pulseQual();
    vBat = 12'd800; remCap = 16'd1000;
    repeat (4) doSample();
    check({taperFlag, calBusy, validDis, edvFinal}, 4'b1111, "R10 flags raised");
    @(negedge clk) fullRst = 1'b1;
    @(negedge clk) fullRst = 1'b0;
    check({taperFlag, calBusy, validDis, edvFirst, edvFinal, updateReq}, 0, "R10 full reset clears");
    check(capInaccurate, 1, "R2 full reset sets");
    pulsePart(1'b0);
    check(capInaccurate, 1, "R4 partial keeps set flag");
    repeat (4) doSample();
    pulseQual();
    pulsePart(1'b0);
    check({taperFlag, calBusy, validDis, edvFinal}, 0, "R10 partial reset clears");
    calActive = 1'b0; taperOk = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule